// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial management bus. It holds a small bank of 8-bit configuration registers and drives their contents straight into the clock-control logic beside it. A master reaches the bank by addressing the slave and sending a command byte. Bits 6:0 of the command select the first register. Bit 7 selects the transfer kind: 1 for a single-byte transfer, 0 for a block transfer that carries a byte count.

The bus lines are sampled in the block's own clock domain. Start and stop conditions are found from the sampled levels, and the slave acknowledges by pulling the data line low through an open-drain enable. The slave never stretches the clock. Block writes take a byte count first, then data for consecutive registers. Block reads return a byte count first, then consecutive registers until the master stops acknowledging. A single-byte read re-addresses the slave with a repeated start after the command byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the open-drain enable is low and every register holds its reset value, with reserved bits cleared.
- R2: A slave address other than the configured one gets no acknowledge. SDA stays released for the whole transfer and the registers are untouched.
- R3: A write whose command has bit 7 set stores the next byte in the register given by command bits 6:0 and acknowledges it. Any further data byte gets a not-acknowledge and is discarded.
- R4: A single-byte read (command with bit 7 set, repeated start, address with read) returns the selected register.
- R5: A block write (command bit 7 clear) takes the first data byte as a count N. The next N bytes go to consecutive registers starting at the command index, and any byte past N gets a not-acknowledge and is not stored.
- R6: A block read first returns a count equal to the number of registers from the start index to the end of the bank. It then returns consecutive registers until the master sends a not-acknowledge.
- R7: Reserved bits (a parameter mask) always read 0 and ignore writes.
- R8: A start or stop condition in the middle of a byte abandons that byte without storing it, and the next transaction proceeds normally.
- R9: A register index at or beyond the bank size ignores writes and reads as 0, and a block read from there reports a count of 0.
- R10: The slave changes its SDA drive only while SCL is low, and the register outputs change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | NUM_REGS*8 | Register contents, register i at bits i*8+7:i*8 |

## Verification
The hardest case to reach is a bus condition that arrives partway through a byte. The stimulus clocks out only part of a byte and then issues a stop or a repeated start. It then confirms through the register outputs that nothing was stored, and confirms that a fresh transaction still works. A second hard case is a block write that runs past its own count, which checks that the stray byte is refused on the acknowledge bit and not stored. Block reads are checked both from the middle of the bank and from an index beyond it, where the returned count must be zero.

// File: rtl/smb_pkg.sv
// Package: shared types for the two-wire configuration slave.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_pkg;
    // Transaction-level states of the protocol engine
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_RECV,   // shifting in a byte from the master
        ST_RACK,   // slave acknowledge clock (may be driven or released)
        ST_SEND,   // shifting out a byte to the master
        ST_SACK,   // master acknowledge clock after a sent byte
        ST_SKIP    // transfer not for us or finished: ignore until start/stop
    } smb_state_t;

    // Write-side progress after the address byte
    typedef enum logic [1:0] {
        WP_CMD,    // next byte is the command
        WP_FIRST,  // next byte is single data or the block count
        WP_BLOCK,  // block data, limited by the remaining count
        WP_DONE    // everything else is refused
    } smb_wphase_t;
endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings SCL and SDA into the clk domain and derives single-cycle
// edge and bus-condition strobes from the synchronized levels.
// Assumes: clk runs many times faster than SCL; STAGES >= 2.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains plus one history stage; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= {STAGES{1'b1}};
            sda_pipe <= {STAGES{1'b1}};
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized levels
    always_comb begin
        scl_lvl   = scl_pipe[STAGES-1];
        sda_lvl   = sda_pipe[STAGES-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/smb_reg_bank.sv
// Module: smb_reg_bank
// Holds NUM_REGS 8-bit registers with a per-bit reserved mask.
// Reserved bits are held at 0. Out-of-range indices read 0 and
// ignore writes.
// Assumes: one write per cycle at most.
module smb_reg_bank #(
    parameter int              NUM_REGS  = 8,
    parameter int              IDX_W     = 7,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0,
    parameter logic [NUM_REGS*8-1:0] RSVD_MASK = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    logic [7:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RMASK = RSVD_MASK[g*8 +: 8];
        localparam logic [7:0] RINIT = RESET_VAL[g*8 +: 8] & ~RMASK;

        // One register: reset value, masked write on index match
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= RINIT;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                regs[g] <= wr_data & ~RMASK;
            end
        end

        assign cfg_o[g*8 +: 8] = regs[g];
    end

    // Read mux with zero for indices outside the bank
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(rd_idx) == i) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/smb_proto_fsm.sv
// Module: smb_proto_fsm
// Bit, byte and transaction engine of the slave: address match,
// command decode, byte count handling, auto-increment and the
// acknowledge drive. All SDA changes happen on a detected SCL fall.
// Assumes: strobes from smb_line_sync; no clock stretching needed.
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         NUM_REGS   = 8,
    parameter int         IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    localparam logic [7:0] BANK_SIZE = 8'(NUM_REGS);

    smb_state_t  state;
    smb_wphase_t wphase;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic [7:0]  tx;
    logic [7:0]  remain;
    logic        is_addr;
    logic        rd_dir;
    logic        byte_mode;
    logic        cnt_pending;
    logic        mack;
    logic [7:0]  blk_count;
    logic [7:0]  next_tx;

    // Count of registers from the current index to the end of the bank
    always_comb begin
        if (8'(ptr) < BANK_SIZE) blk_count = BANK_SIZE - 8'(ptr);
        else                     blk_count = 8'h00;
        next_tx = cnt_pending ? blk_count : rd_data;
    end

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            wphase      <= WP_CMD;
            bit_cnt     <= '0;
            shreg       <= '0;
            tx          <= '0;
            remain      <= '0;
            is_addr     <= 1'b0;
            rd_dir      <= 1'b0;
            byte_mode   <= 1'b1;
            cnt_pending <= 1'b0;
            mack        <= 1'b0;
            ptr         <= '0;
            wr_en       <= 1'b0;
            wr_data     <= '0;
            sda_oe      <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RECV;
                is_addr <= 1'b1;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                if (shreg[7:1] == SLAVE_ADDR) begin
                                    rd_dir      <= shreg[0];
                                    wphase      <= WP_CMD;
                                    cnt_pending <= shreg[0] & ~byte_mode;
                                    sda_oe      <= 1'b1;
                                    state       <= ST_RACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                case (wphase)
                                    WP_CMD: begin
                                        ptr       <= shreg[IDX_W-1:0];
                                        byte_mode <= shreg[7];
                                        wphase    <= WP_FIRST;
                                        sda_oe    <= 1'b1;
                                        state     <= ST_RACK;
                                    end
                                    WP_FIRST: begin
                                        if (byte_mode) begin
                                            wr_en   <= 1'b1;
                                            wr_data <= shreg;
                                            wphase  <= WP_DONE;
                                        end else begin
                                            remain <= shreg;
                                            wphase <= WP_BLOCK;
                                        end
                                        sda_oe <= 1'b1;
                                        state  <= ST_RACK;
                                    end
                                    WP_BLOCK: begin
                                        if (remain != 8'h00) begin
                                            wr_en   <= 1'b1;
                                            wr_data <= shreg;
                                            remain  <= remain - 8'd1;
                                            sda_oe  <= 1'b1;
                                            state   <= ST_RACK;
                                        end else begin
                                            state <= ST_SKIP;
                                        end
                                    end
                                    default: state <= ST_SKIP;
                                endcase
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            if (wr_en) ptr <= ptr;
                            if (rd_dir) begin
                                tx     <= next_tx;
                                sda_oe <= ~next_tx[7];
                                if (cnt_pending) cnt_pending <= 1'b0;
                                else             ptr <= ptr + 1'b1;
                                bit_cnt <= '0;
                                state   <= ST_SEND;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RECV;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_SACK;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    ST_SACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx     <= next_tx;
                                sda_oe <= ~next_tx[7];
                                if (cnt_pending) cnt_pending <= 1'b0;
                                else             ptr <= ptr + 1'b1;
                                bit_cnt <= '0;
                                state   <= ST_SEND;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
                // Block data advances the index once its write is issued
                if (wr_en && !byte_mode) ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smb_cfg_slave.sv
// Module: smb_cfg_slave (top)
// Two-wire bus slave giving byte and block access to a bank of
// configuration registers whose contents drive cfg_o.
// Assumes: sda_oe_o drives an open-drain pad; sda_i is the bus level.
module smb_cfg_slave #(
    parameter logic [6:0]            SLAVE_ADDR  = 7'h69,
    parameter int                    NUM_REGS    = 8,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL   = 64'h0F1E_2D3C_4B5A_6978,
    parameter logic [NUM_REGS*8-1:0] RSVD_MASK   = 64'h0000_0100_00C0_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDX_W = 7;

    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [IDX_W-1:0] ptr;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smb_proto_fsm #(
        .SLAVE_ADDR(SLAVE_ADDR),
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .RESET_VAL(RESET_VAL),
        .RSVD_MASK(RSVD_MASK)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (ptr),
        .wr_data(wr_data),
        .rd_idx (ptr),
        .rd_data(rd_data),
        .cfg_o  (cfg_o)
    );
endmodule

// File: rtl/smb_cfg_checker.sv
// Module: smb_cfg_checker
// Protocol and output properties of smb_cfg_slave, attached by bind.
// Assumes: the same parameters as the bound instance.
module smb_cfg_checker #(
    parameter int                    NUM_REGS  = 8,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0,
    parameter logic [NUM_REGS*8-1:0] RSVD_MASK = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] cfg_o
);
    // R1: first cycle out of reset shows a quiet line and reset contents
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sda_oe_o && cfg_o == (RESET_VAL & ~RSVD_MASK)));

    // R7: reserved bits never read as 1
    a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o & RSVD_MASK) == '0);

    // R10: SDA drive moves only while the bus clock is low
    a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R10: register outputs move only while the bus clock is low
    a_r10_cfg_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o != $past(cfg_o)) |-> !scl_i);
endmodule

bind smb_cfg_slave smb_cfg_checker #(
    .NUM_REGS (NUM_REGS),
    .RESET_VAL(RESET_VAL),
    .RSVD_MASK(RSVD_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe_o(sda_oe_o),
    .cfg_o   (cfg_o)
);

// File: tb/tb_smb_cfg_slave.sv
// Bench for smb_cfg_slave: a bus master model drives transactions,
// pushes expected read bytes into a queue, and a monitor compares
// each byte the master receives against that queue.
module tb_smb_cfg_slave;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int         NR   = 8;
    localparam int         Q    = 8;   // clocks per quarter bus bit

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic [NR*8-1:0] cfg;
    wire           sda_bus = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int edge_viol = 0;
    logic [7:0] model [NR];
    logic [7:0] rmask [NR];
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    smb_cfg_slave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .sda_oe_o(sda_oe),
        .cfg_o   (cfg)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every received byte with the scoreboard queue
    always @(negedge clk) begin
        if (act_q.size() != 0) begin
            logic [7:0] a;
            logic [7:0] e;
            string      t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(a == e, t, a, e);
        end
    end

    // R10: SDA drive may only move while SCL is low
    logic sda_oe_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe != sda_oe_q && scl) edge_viol++;
        sda_oe_q <= sda_oe;
    end

    task automatic qw(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
        end
    endtask

    // Send a byte; acked = 1 when the slave pulled SDA low on the 9th clock
    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; qw(); scl = 1'b1; qw();
        acked = ~sda_bus;
        qw(); scl = 1'b0; qw();
    endtask

    // Receive a byte and answer with ack (1) or not-ack (0)
    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qw(); scl = 1'b1; qw();
            b = {b[6:0], sda_bus};
            qw(); scl = 1'b0; qw();
        end
        sda_m = ~give_ack; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic expect_read(input logic [7:0] e, input bit give_ack, input string tag);
        logic [7:0] b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        recv_byte(give_ack, b);
        act_q.push_back(b);
    endtask

    task automatic model_wr(input int idx, input logic [7:0] d);
        if (idx < NR) model[idx] = d & ~rmask[idx];
    endtask

    task automatic check_cfg(input string req);
        for (int i = 0; i < NR; i++)
            check(cfg[i*8 +: 8] == model[i], req, cfg[i*8 +: 8], model[i]);
    endtask

    task automatic byte_write(input int idx, input logic [7:0] d, input string req);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); check(a, req, a, 1);
        send_byte(8'h80 | 8'(idx), a); check(a, req, a, 1);
        send_byte(d, a); check(a, req, a, 1);
        bus_stop();
        model_wr(idx, d);
    endtask

    task automatic byte_read(input int idx, input string req);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h80 | 8'(idx), a);
        bus_start();
        send_byte({ADDR, 1'b1}, a); check(a, req, a, 1);
        expect_read(idx < NR ? model[idx] : 8'h00, 1'b0, req);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < NR; i++) rmask[i] = 8'h00;
        rmask[2] = 8'hC0;
        rmask[5] = 8'h01;
        model[0] = 8'h78; model[1] = 8'h69; model[2] = 8'h5A; model[3] = 8'h4B;
        model[4] = 8'h3C; model[5] = 8'h2D; model[6] = 8'h1E; model[7] = 8'h0F;
        for (int i = 0; i < NR; i++) model[i] = model[i] & ~rmask[i];

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        check_cfg("R1 reset contents");

        // R2: wrong address write gets no ack and changes nothing
        bus_start();
        send_byte({7'h2A, 1'b0}, a); check(!a, "R2 no ack on mismatch", a, 0);
        send_byte(8'h81, a); check(!a, "R2 no ack on command", a, 0);
        send_byte(8'h00, a); check(!a, "R2 no ack on data", a, 0);
        bus_stop();
        check_cfg("R2 registers untouched");

        // R2: wrong address read sees a released line
        bus_start();
        send_byte({7'h2A, 1'b1}, a);
        exp_q.push_back(8'hFF); tag_q.push_back("R2 read mismatch");
        recv_byte(1'b0, b); act_q.push_back(b);
        bus_stop();

        // R3: single-byte write, extra byte refused
        bus_start();
        send_byte({ADDR, 1'b0}, a); check(a, "R3 addr ack", a, 1);
        send_byte(8'h81, a); check(a, "R3 cmd ack", a, 1);
        send_byte(8'hA7, a); check(a, "R3 data ack", a, 1);
        send_byte(8'h55, a); check(!a, "R3 extra byte nack", a, 0);
        bus_stop();
        model_wr(1, 8'hA7);
        check_cfg("R3 single write");

        // R4: single-byte read with repeated start
        byte_read(1, "R4 byte read reg1");
        byte_read(7, "R4 byte read reg7");

        // R5: block write count 3 at index 3, fourth byte refused
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h03, a); check(a, "R5 cmd ack", a, 1);
        send_byte(8'h03, a); check(a, "R5 count ack", a, 1);
        send_byte(8'h11, a); check(a, "R5 data0 ack", a, 1);
        send_byte(8'h22, a); check(a, "R5 data1 ack", a, 1);
        send_byte(8'h33, a); check(a, "R5 data2 ack", a, 1);
        send_byte(8'h44, a); check(!a, "R5 past count nack", a, 0);
        bus_stop();
        model_wr(3, 8'h11); model_wr(4, 8'h22); model_wr(5, 8'h33);
        check_cfg("R5 R7 block write");

        // R7: reserved bits ignore writes and read as 0
        byte_write(2, 8'hFF, "R7 write reserved");
        check(cfg[23:16] == 8'h3F, "R7 reg2 masked", cfg[23:16], 8'h3F);
        byte_read(2, "R7 read reg2");

        // R6: block read from index 2: count 6 then registers 2..7
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h02, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a); check(a, "R6 read addr ack", a, 1);
        expect_read(8'd6, 1'b1, "R6 count");
        for (int i = 2; i < NR; i++)
            expect_read(model[i], i != NR - 1, "R6 block data");
        bus_stop();

        // R8: stop in the middle of a block data byte
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h06, a);
        send_byte(8'h01, a);
        send_bits(8'hC3, 4);
        bus_stop();
        check_cfg("R8 stop mid byte");

        // R8: repeated start in the middle of a byte, then a fresh write
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h87, a);
        send_bits(8'h5A, 3);
        bus_start();
        send_byte({ADDR, 1'b0}, a); check(a, "R8 restart addr ack", a, 1);
        send_byte(8'h87, a);
        send_byte(8'hE4, a); check(a, "R8 fresh data ack", a, 1);
        bus_stop();
        model_wr(7, 8'hE4);
        check_cfg("R8 after restart");

        // R9: out-of-range index
        byte_write(8'h70, 8'hAB, "R9 write beyond bank");
        check_cfg("R9 no change");
        byte_read(8'h70, "R9 read beyond bank");
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h70, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        expect_read(8'd0, 1'b0, "R9 block count zero");
        bus_stop();

        // R10: SDA drive never moved while SCL was high
        check(edge_viol == 0, "R10 sda edges", edge_viol, 0);

        qw(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule